// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

This block takes a requested output frequency and the frequencies of three possible reference sources (a crystal and two PLLs). It finds the divider setting whose output comes closest to the request. A setting is a source choice, a fractional predivider of 2, 2.5 or 3, and an integer divide. To keep all arithmetic in integers, every source rate is doubled and the predivider is carried as twice its value (4, 5 or 6). A single shared shift-subtract divider serves the whole search, and the nine source/predivider pairs are visited one after another.

Software or a configuration sequencer pulses `start` with the operands on the inputs. It then waits for `done` and copies the two select flags, the predivider code and the divide value into a clock divider elsewhere. `rate_out` is the frequency that setting produces. `not_found` says that no legal setting exists.

The controller has these states:

| State | Role |
|---|---|
| ST_IDLE | Waits for `start` after reset. |
| ST_CLAMP | Limits the request and checks it for zero. |
| ST_QUOT_GO | Launches the divide that gives the candidate divide value. |
| ST_QUOT_WAIT | Waits for that divide, then checks the range. |
| ST_ACH_GO | Launches the divide that gives the achieved rate. |
| ST_ACH_WAIT | Waits for that divide. |
| ST_SCORE | Offers the candidate to the best-result keeper. |
| ST_ADVANCE | Steps to the next predivider or source. |
| ST_FINISH | Holds the results with `done` high. |

The transitions are:

- **IDLE→CLAMP and FINISH→CLAMP** on `start`.
- **CLAMP→FINISH** when the limited request is zero.
- **CLAMP→QUOT_GO** otherwise.
- **QUOT_GO→QUOT_WAIT** always.
- **QUOT_WAIT→ACH_GO** when the divide value is in range.
- **QUOT_WAIT→ADVANCE** when it is out of range.
- **ACH_GO→ACH_WAIT** always.
- **ACH_WAIT→SCORE** when the divider finishes.
- **SCORE→ADVANCE** always.
- **ADVANCE→QUOT_GO** while pairs remain.
- **ADVANCE→FINISH** after the ninth pair.

Top module: `clkdiv_search`

## Requirements
- R1: After reset, `done`, `not_found`, `esel`, `psel`, `pdiv_code`, `div_val` and `rate_out` are all 0.
- R2: The requested rate used by the search is the smaller of `req_rate` and floor(max(source rates)/4).
- R3: Pairs are visited in the order: crystal, then PLL1, then PLL2. Within each source the doubled predivider P runs 4, 5, 6. A candidate replaces the held best only if it is the first valid candidate or its absolute error is strictly smaller. On equal error the earlier candidate is kept.
- R4: The candidate divide D is floor(2·source / (rate·P)). A candidate with D < 2 or D > 127 is skipped.
- R5: `rate_out` equals floor(2·source / (P·D)) of the chosen candidate.
- R6: `pdiv_code` = P − 3, so 1 means 2, 2 means 2.5 and 3 means 3. `esel` = 1 for PLL1 or PLL2. `psel` = 1 only for PLL2. The crystal gives `esel` = 0 and `psel` = 0.
- R7: `not_found` = 1 when no candidate is valid or the limited rate is zero (this includes `req_rate` = 0). In that case `esel`, `psel`, `pdiv_code`, `div_val` and `rate_out` read 0.
- R8: `done` goes low the cycle after an accepted `start`. It rises once all nine pairs have been evaluated. While `done` is high and no `start` arrives, all result outputs hold their values.
- R9: Operands are sampled only when `start` is accepted. Input changes during a search, and `start` pulses during a search, have no effect on that search's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (accepted in ST_IDLE or ST_FINISH) |
| req_rate | input | RATE_W | Requested output frequency |
| src_xtal | input | RATE_W | Crystal source frequency |
| src_pll1 | input | RATE_W | First PLL frequency |
| src_pll2 | input | RATE_W | Second PLL frequency |
| done | output | 1 | Result valid; stays high until the next accepted start |
| not_found | output | 1 | No legal setting exists |
| esel | output | 1 | PLL selected (either PLL) |
| psel | output | 1 | Second PLL selected |
| pdiv_code | output | 2 | Predivider code, doubled predivider minus 3 |
| div_val | output | DIV_W | Integer divide value |
| rate_out | output | RATE_W | Achieved output frequency |

## Verification
A fault in the pair counters or the keeper's comparison shows at the ports when `done` rises. It appears as a wrong source flag, predivider code or divide value, or as the later of two tying candidates winning. Equal-frequency sources and exactly divisible requests make such faults visible. A corrupted shared divider or a wrong clamp shows as a `rate_out` or `div_val` that differs from the reference arithmetic on the first search that uses that path. A broken operand capture shows only when the inputs change while a search is running, so the bench changes them during searches.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLAMP,
        ST_QUOT_GO,
        ST_QUOT_WAIT,
        ST_ACH_GO,
        ST_ACH_WAIT,
        ST_SCORE,
        ST_ADVANCE,
        ST_FINISH
    } srch_state_t;

    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned P2_FIRST = 4;
    localparam int unsigned P2_LAST  = 6;
    localparam int unsigned P2_BIAS  = 3;

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int unsigned N_W = 33,
    parameter int unsigned D_W = 35
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [N_W-1:0] num,
    input  logic [D_W-1:0] den,
    output logic           valid,
    output logic [N_W-1:0] quo
);
    localparam int unsigned CNT_W = $clog2(N_W + 1);
    localparam int unsigned PW    = N_W + D_W + 1;

    logic [D_W-1:0]   rem_q;
    logic [D_W-1:0]   den_q;
    logic [N_W-1:0]   num_q;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [D_W:0]     shifted;
    logic [D_W-1:0]   rem_n;
    logic             qbit;

    always_comb begin
        shifted = {rem_q, quo[N_W-1]};
        qbit    = (shifted >= {1'b0, den_q});
        rem_n   = qbit ? D_W'(shifted - {1'b0, den_q}) : shifted[D_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            num_q <= '0;
            quo   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo   <= num;
                num_q <= num;
                den_q <= den;
                cnt   <= CNT_W'(N_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= rem_n;
                quo   <= {quo[N_W-2:0], qbit};
                cnt   <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    AST_QUOT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && den_q != '0) |->
        ((PW'(quo) * PW'(den_q) + PW'(rem_q) == PW'(num_q)) && (rem_q < den_q))); // R4

endmodule

// File: rtl/best_keeper.sv
module best_keeper #(
    parameter int unsigned RATE_W = 32,
    parameter int unsigned DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              offer,
    input  logic              c_esel,
    input  logic              c_psel,
    input  logic [1:0]        c_pcode,
    input  logic [DIV_W-1:0]  c_div,
    input  logic [RATE_W-1:0] c_rate,
    input  logic [RATE_W-1:0] c_err,
    output logic              has_best,
    output logic              b_esel,
    output logic              b_psel,
    output logic [1:0]        b_pcode,
    output logic [DIV_W-1:0]  b_div,
    output logic [RATE_W-1:0] b_rate
);
    logic [RATE_W-1:0] b_err;
    logic              take;

    assign take = offer && (!has_best || (c_err < b_err));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            has_best <= 1'b0;
            b_esel   <= 1'b0;
            b_psel   <= 1'b0;
            b_pcode  <= '0;
            b_div    <= '0;
            b_rate   <= '0;
            b_err    <= '0;
        end else if (clear) begin
            has_best <= 1'b0;
            b_esel   <= 1'b0;
            b_psel   <= 1'b0;
            b_pcode  <= '0;
            b_div    <= '0;
            b_rate   <= '0;
            b_err    <= '0;
        end else if (take) begin
            has_best <= 1'b1;
            b_esel   <= c_esel;
            b_psel   <= c_psel;
            b_pcode  <= c_pcode;
            b_div    <= c_div;
            b_rate   <= c_rate;
            b_err    <= c_err;
        end
    end

    AST_KEEP_IMPROVES: assert property (@(posedge clk) disable iff (!rst_n)
        (has_best && offer && !clear) |=> (has_best && b_err <= $past(b_err))); // R3

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
    import clkdiv_search_pkg::*;
#(
    parameter int unsigned RATE_W  = 32,
    parameter int unsigned DIV_W   = 7,
    parameter int unsigned DIV_MIN = 2,
    parameter int unsigned DIV_MAX = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] src_xtal,
    input  logic [RATE_W-1:0] src_pll1,
    input  logic [RATE_W-1:0] src_pll2,
    output logic              done,
    output logic              not_found,
    output logic              esel,
    output logic              psel,
    output logic [1:0]        pdiv_code,
    output logic [DIV_W-1:0]  div_val,
    output logic [RATE_W-1:0] rate_out
);
    localparam int unsigned N_W = RATE_W + 1;
    localparam int unsigned D_W = RATE_W + 3;

    srch_state_t state, state_n;

    logic [RATE_W-1:0] req_q, rate_q, ach_q;
    logic [RATE_W-1:0] src_q [NUM_SRC];
    logic [1:0]        src_idx;
    logic [2:0]        p2;
    logic [DIV_W-1:0]  cand_div;

    logic              accept, keep_clear, offer;
    logic [RATE_W-1:0] max_src, clamp_lim, clamped, cur_src, err;
    logic              dv_go, dv_valid;
    logic [N_W-1:0]    dv_num, dv_quo;
    logic [D_W-1:0]    dv_den;
    logic              quo_in_range, last_pair;
    logic              has_best;

    assign accept     = start && (state == ST_IDLE || state == ST_FINISH);
    assign keep_clear = accept;

    always_comb begin
        max_src = src_q[0];
        for (int i = 1; i < NUM_SRC; i++)
            if (src_q[i] > max_src) max_src = src_q[i];
        clamp_lim = max_src >> 2;
        clamped   = (req_q < clamp_lim) ? req_q : clamp_lim;
    end

    always_comb begin
        unique case (src_idx)
            2'd0:    cur_src = src_q[0];
            2'd1:    cur_src = src_q[1];
            default: cur_src = src_q[2];
        endcase
    end

    assign dv_num       = {cur_src, 1'b0};
    assign dv_den       = (state == ST_ACH_GO) ? D_W'(p2) * D_W'(cand_div)
                                               : D_W'(rate_q) * D_W'(p2);
    assign dv_go        = (state == ST_QUOT_GO) || (state == ST_ACH_GO);
    assign quo_in_range = (dv_quo >= N_W'(DIV_MIN)) && (dv_quo <= N_W'(DIV_MAX));
    assign last_pair    = (p2 == 3'(P2_LAST)) && (src_idx == 2'(NUM_SRC - 1));
    assign err          = (ach_q >= rate_q) ? ach_q - rate_q : rate_q - ach_q;
    assign offer        = (state == ST_SCORE);

    seq_divider #(.N_W(N_W), .D_W(D_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (dv_go),
        .num   (dv_num),
        .den   (dv_den),
        .valid (dv_valid),
        .quo   (dv_quo)
    );

    best_keeper #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_keep (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (keep_clear),
        .offer    (offer),
        .c_esel   (src_idx != 2'd0),
        .c_psel   (src_idx == 2'd2),
        .c_pcode  (2'(p2 - 3'(P2_BIAS))),
        .c_div    (cand_div),
        .c_rate   (ach_q),
        .c_err    (err),
        .has_best (has_best),
        .b_esel   (esel),
        .b_psel   (psel),
        .b_pcode  (pdiv_code),
        .b_div    (div_val),
        .b_rate   (rate_out)
    );

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE, ST_FINISH: if (start) state_n = ST_CLAMP;
            ST_CLAMP:     state_n = (clamped == '0) ? ST_FINISH : ST_QUOT_GO;
            ST_QUOT_GO:   state_n = ST_QUOT_WAIT;
            ST_QUOT_WAIT: if (dv_valid) state_n = quo_in_range ? ST_ACH_GO : ST_ADVANCE;
            ST_ACH_GO:    state_n = ST_ACH_WAIT;
            ST_ACH_WAIT:  if (dv_valid) state_n = ST_SCORE;
            ST_SCORE:     state_n = ST_ADVANCE;
            ST_ADVANCE:   state_n = last_pair ? ST_FINISH : ST_QUOT_GO;
            default:      state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            rate_q   <= '0;
            ach_q    <= '0;
            src_idx  <= '0;
            p2       <= 3'(P2_FIRST);
            cand_div <= '0;
            for (int i = 0; i < NUM_SRC; i++) src_q[i] <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                req_q    <= req_rate;
                src_q[0] <= src_xtal;
                src_q[1] <= src_pll1;
                src_q[2] <= src_pll2;
                src_idx  <= '0;
                p2       <= 3'(P2_FIRST);
            end
            if (state == ST_CLAMP) rate_q <= clamped;
            if (state == ST_QUOT_WAIT && dv_valid) cand_div <= dv_quo[DIV_W-1:0];
            if (state == ST_ACH_WAIT && dv_valid) ach_q <= dv_quo[RATE_W-1:0];
            if (state == ST_ADVANCE && !last_pair) begin
                if (p2 == 3'(P2_LAST)) begin
                    p2      <= 3'(P2_FIRST);
                    src_idx <= src_idx + 2'd1;
                end else begin
                    p2 <= p2 + 3'd1;
                end
            end
        end
    end

    always_comb begin
        done      = (state == ST_FINISH);
        not_found = done && !has_best;
    end

    AST_CLAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUOT_GO) |-> (rate_q <= req_q && rate_q != '0)); // R2
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !not_found) |-> (div_val >= DIV_W'(DIV_MIN) && div_val <= DIV_W'(DIV_MAX))); // R4
    AST_PCODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !not_found) |-> (pdiv_code != 2'd0)); // R6
    AST_PSEL_ESEL: assert property (@(posedge clk) disable iff (!rst_n)
        psel |-> esel); // R6
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done); // R8
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable({not_found, esel, psel, pdiv_code, div_val, rate_out}))); // R8

endmodule

// File: tb/tb_clkdiv_search.sv
module tb_clkdiv_search;
    localparam int unsigned RATE_W = 32;
    localparam int unsigned DIV_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [RATE_W-1:0] req_rate = '0, src_xtal = '0, src_pll1 = '0, src_pll2 = '0;
    logic              done, not_found, esel, psel;
    logic [1:0]        pdiv_code;
    logic [DIV_W-1:0]  div_val;
    logic [RATE_W-1:0] rate_out;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    clkdiv_search #(.RATE_W(RATE_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
        .src_xtal(src_xtal), .src_pll1(src_pll1), .src_pll2(src_pll2),
        .done(done), .not_found(not_found), .esel(esel), .psel(psel),
        .pdiv_code(pdiv_code), .div_val(div_val), .rate_out(rate_out)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference search, written from the requirements
    task automatic model(input longint req, input longint s0, input longint s1, input longint s2,
                         output bit nf, output int es, output int ps, output int pc,
                         output int dv, output longint rt);
        longint src[3];
        longint mx, r, d, a, e, best;
        bit found;
        src[0] = s0; src[1] = s1; src[2] = s2;
        mx = s0;
        if (s1 > mx) mx = s1;
        if (s2 > mx) mx = s2;
        r = (req < mx / 4) ? req : mx / 4;
        found = 0; best = 0;
        es = 0; ps = 0; pc = 0; dv = 0; rt = 0;
        if (r != 0) begin
            for (int i = 0; i < 3; i++) begin
                for (int p = 4; p <= 6; p++) begin
                    d = (2 * src[i]) / (r * p);
                    if (d < 2 || d > 127) continue;
                    a = (2 * src[i]) / (p * d);
                    e = (a >= r) ? a - r : r - a;
                    if (!found || e < best) begin
                        found = 1; best = e;
                        es = (i != 0); ps = (i == 2); pc = p - 3; dv = int'(d); rt = a;
                    end
                end
            end
        end
        nf = !found;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R8 done"}, done, 1);
    endtask

    task automatic compare(input string tag, input longint req, input longint s0,
                           input longint s1, input longint s2);
        bit nf; int es, ps, pc, dv; longint rt;
        model(req, s0, s1, s2, nf, es, ps, pc, dv, rt);
        chk({tag, " R7 not_found"}, not_found, nf);
        chk({tag, " R6 esel"}, esel, es);
        chk({tag, " R6 psel"}, psel, ps);
        chk({tag, " R6 pdiv_code"}, pdiv_code, pc);
        chk({tag, " R4 div_val"}, div_val, dv);
        chk({tag, " R5 rate_out"}, rate_out, rt);
    endtask

    task automatic run(input string tag, input longint req, input longint s0,
                       input longint s1, input longint s2);
        @(negedge clk);
        req_rate = RATE_W'(req); src_xtal = RATE_W'(s0);
        src_pll1 = RATE_W'(s1); src_pll2 = RATE_W'(s2);
        pulse_start();
        chk({tag, " R8 done low after start"}, done, 0);
        wait_done(tag);
        compare(tag, req, s0, s1, s2);
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0);
        chk("R1 not_found", not_found, 0);
        chk("R1 esel", esel, 0);
        chk("R1 psel", psel, 0);
        chk("R1 pdiv_code", pdiv_code, 0);
        chk("R1 div_val", div_val, 0);
        chk("R1 rate_out", rate_out, 0);
        rst_n = 1'b1;

        // R3 tie: equal sources, exact divide; crystal with P=4 must win
        run("R3 tie", 1000000, 12000000, 12000000, 12000000);
        chk("R3 tie esel", esel, 0);
        chk("R3 tie div", div_val, 6);
        chk("R6 tie pcode", pdiv_code, 1);

        // R6: only PLL2 usable
        run("R6 pll2", 2000000, 0, 0, 48000000);
        chk("R6 pll2 psel", psel, 1);
        chk("R6 pll2 esel", esel, 1);
        chk("R4 pll2 div", div_val, 12);

        // R2: clamp of an oversized request
        run("R2 clamp", 100000000, 14745600, 0, 0);
        chk("R2 clamp rate", rate_out, 3686400);
        chk("R2 clamp div", div_val, 2);

        // R7: zero request, all divides too large, tiny sources
        run("R7 zero", 0, 14745600, 200000000, 300000000);
        chk("R7 zero nf", not_found, 1);
        run("R7 toolarge", 1000, 14745600, 0, 0);
        chk("R7 toolarge nf", not_found, 1);
        run("R7 tiny", 5, 3, 2, 1);
        chk("R7 tiny nf", not_found, 1);

        // R4: range edge near 127 and 2
        run("R4 edge hi", 100000, 0, 25400000, 0);
        run("R4 edge lo", 24000000, 0, 0, 96000000);

        // R9 and R8: inputs and start change mid-search, then hold after done
        begin
            longint rq = 7300000, a0 = 14745600, a1 = 368640000, a2 = 250000000;
            @(negedge clk);
            req_rate = RATE_W'(rq); src_xtal = RATE_W'(a0);
            src_pll1 = RATE_W'(a1); src_pll2 = RATE_W'(a2);
            pulse_start();
            repeat (40) @(negedge clk);
            req_rate = 32'd123; src_xtal = 32'd999; src_pll1 = 32'd5; src_pll2 = 32'd77;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done("R9");
            compare("R9 sampled", rq, a0, a1, a2);
            repeat (20) @(negedge clk);
            chk("R8 hold done", done, 1);
            compare("R8 hold", rq, a0, a1, a2);
        end

        // Random mix
        for (int k = 0; k < 40; k++) begin
            longint s1 = 50000000 + longint'($urandom % 350000000);
            longint s2 = ($urandom % 2) ? 0 : longint'($urandom % 500000000);
            longint rq = 1 + longint'($urandom % 120000000);
            if (k % 4 == 0) rq = 1 + longint'($urandom % 5000000);
            run("R3 random", rq, 14745600, s1, s2);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule